// File: doc/BRIEF.md
# Dual Address Pointer Bank with Per-Pointer Auto-Step

This block holds a small bank of 16-bit address pointers for indirect external memory moves. A select register picks the active pointer, and the block drives that pointer's value on the address output. Software loads each pointer one byte at a time through a register write port. Each pointer also has its own step mode: hold, increment or decrement.

Every access strobe steps only the active pointer, and only by that pointer's own mode. One pointer can therefore walk through a buffer while a second pointer stays on a fixed peripheral address. Software switches between the two with the select register and does not have to reload either one. The block does not decode instructions or run the bus cycle. It only keeps and steps the addresses.

Top module: `addr_ptr_bank`

## Requirements
- R1: After the asynchronous active-low reset, every pointer is 0000h, every mode is hold, and pointer 0 is selected. A strobe that follows leaves addr_o at 0000h.
- R2: addr_o always shows the pointer whose index is held in the select register. A select write (sel_wr_en_i, index in sel_wr_data_i) takes effect on the next clock edge.
- R3: A pointer byte write loads ptr_wr_data_i into one byte of pointer ptr_wr_idx_i on the next edge. ptr_wr_byte_i=0 picks bits 7:0 and ptr_wr_byte_i=1 picks bits 15:8. The other byte is left unchanged.
- R4: A mode write sets the mode of pointer mode_wr_idx_i on the next edge. The mode encoding is 2'b00 hold, 2'b01 increment and 2'b10 decrement. Each pointer keeps its own mode.
- R5: On the clock edge that samples access_i high, only the active pointer is stepped, and it follows its own mode. During the strobe cycle addr_o shows the value from before the step. Inactive pointers do not change.
- R6: Stepping wraps modulo 2^16. An increment from FFFFh gives 0000h, and a decrement from 0000h gives FFFFh.
- R7: Mode code 2'b11 is reserved and behaves as hold.
- R8: A byte write to the active pointer in a strobe cycle takes priority over the step. No step happens, and the byte that was not written keeps its value from before the strobe.
- R9: A select write or mode write in the same cycle as a strobe does not affect that strobe. The strobe uses the select value and mode value held before that edge.
- R10: A byte write to an inactive pointer in a strobe cycle and the step of the active pointer both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ptr_wr_en_i | input | 1 | Pointer byte write enable |
| ptr_wr_idx_i | input | 1 | Index of the pointer to write |
| ptr_wr_byte_i | input | 1 | Byte lane: 0 low, 1 high |
| ptr_wr_data_i | input | 8 | Byte to write |
| sel_wr_en_i | input | 1 | Select register write enable |
| sel_wr_data_i | input | 1 | New active pointer index |
| mode_wr_en_i | input | 1 | Mode write enable |
| mode_wr_idx_i | input | 1 | Index of the pointer whose mode is written |
| mode_wr_data_i | input | 2 | Mode code |
| access_i | input | 1 | Access strobe; steps the active pointer |
| addr_o | output | 16 | Value of the active pointer |

## Verification
The bench drives the pointers across FFFFh and 0000h in both directions. A design without the wrap would saturate or carry into a wider value. It applies a strobe together with a byte write to the same pointer, where a wrong priority would show a stepped high byte or a lost write. It also applies a strobe together with select and mode writes, where a design that read the new values would step the wrong pointer or step in the wrong direction. Reserved mode codes and a fixed second pointer are checked so that a design stepping inactive pointers, or treating code 11 as a step, shows up as a moved address. A long seeded random run then checks addr_o against a bench model on every cycle.

// File: rtl/addr_ptr_pkg.sv
package addr_ptr_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_INC  = 2'b01,
    STEP_DEC  = 2'b10,
    STEP_RSVD = 2'b11
  } step_mode_e;
endpackage

// File: rtl/ptr_stepper.sv
module ptr_stepper
  import addr_ptr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  step_mode_e       mode_i,
  input  logic [PTR_W-1:0] val_i,
  output logic [PTR_W-1:0] val_o
);
  // natural width truncation gives the modulo 2^PTR_W wrap
  always_comb begin
    unique case (mode_i)
      STEP_INC: val_o = val_i + PTR_W'(1);
      STEP_DEC: val_o = val_i - PTR_W'(1);
      default:  val_o = val_i;
    endcase
  end
endmodule

// File: rtl/ptr_slot.sv
module ptr_slot
  import addr_ptr_pkg::*;
#(
  parameter int PTR_W  = 16,
  localparam int NB     = PTR_W / 8,
  localparam int BSEL_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_en_i,
  input  logic              wr_en_i,
  input  logic [BSEL_W-1:0] wr_byte_i,
  input  logic [7:0]        wr_data_i,
  input  logic              mode_wr_en_i,
  input  logic [1:0]        mode_wr_data_i,
  output logic [PTR_W-1:0]  ptr_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d, stepped;
  step_mode_e       mode_q;

  ptr_stepper #(.PTR_W(PTR_W)) u_step (
    .mode_i(mode_q),
    .val_i (ptr_q),
    .val_o (stepped)
  );

  // byte write wins over the step
  always_comb begin
    ptr_d = ptr_q;
    if (step_en_i && !wr_en_i) ptr_d = stepped;
    for (int b = 0; b < NB; b++) begin
      if (wr_en_i && wr_byte_i == BSEL_W'(b)) ptr_d[b*8 +: 8] = wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      mode_q <= STEP_HOLD;
    end else begin
      ptr_q <= ptr_d;
      if (mode_wr_en_i) mode_q <= step_mode_e'(mode_wr_data_i);
    end
  end

  assign ptr_o = ptr_q;

  assert_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_en_i && !wr_en_i |=> $stable(ptr_q));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_i && !wr_en_i && mode_q == STEP_HOLD |=> $stable(ptr_q));

  assert_rsvd_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_i && !wr_en_i && mode_q == STEP_RSVD |=> $stable(ptr_q));

  assert_inc_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_i && !wr_en_i && mode_q == STEP_INC |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1));

  assert_dec_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_i && !wr_en_i && mode_q == STEP_DEC |=> ptr_q == PTR_W'($past(ptr_q) - 1'b1));

  for (genvar b = 0; b < NB; b++) begin : g_lane_chk
    assert_byte_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && wr_byte_i == BSEL_W'(b) |=> ptr_q[b*8 +: 8] == $past(wr_data_i));
    assert_byte_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && wr_byte_i != BSEL_W'(b) |=> $stable(ptr_q[b*8 +: 8]));
  end
endmodule

// File: rtl/ptr_select.sv
module ptr_select #(
  parameter int NUM_PTRS = 2,
  localparam int SEL_W   = (NUM_PTRS > 1) ? $clog2(NUM_PTRS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_wr_en_i,
  input  logic [SEL_W-1:0] sel_wr_data_i,
  output logic [SEL_W-1:0] sel_o
);
  logic [SEL_W-1:0] sel_q;
  logic             in_range;

  // out-of-range indices are dropped
  assign in_range = 32'(sel_wr_data_i) < NUM_PTRS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      sel_q <= '0;
    else if (sel_wr_en_i && in_range) sel_q <= sel_wr_data_i;
  end

  assign sel_o = sel_q;

  assert_sel_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_wr_en_i |=> $stable(sel_q));

  assert_sel_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr_en_i && in_range |=> sel_q == $past(sel_wr_data_i));
endmodule

// File: rtl/addr_ptr_bank.sv
module addr_ptr_bank
  import addr_ptr_pkg::*;
#(
  parameter int NUM_PTRS = 2,
  parameter int PTR_W    = 16,
  localparam int SEL_W   = (NUM_PTRS > 1) ? $clog2(NUM_PTRS) : 1,
  localparam int NB      = PTR_W / 8,
  localparam int BSEL_W  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ptr_wr_en_i,
  input  logic [SEL_W-1:0]  ptr_wr_idx_i,
  input  logic [BSEL_W-1:0] ptr_wr_byte_i,
  input  logic [7:0]        ptr_wr_data_i,
  input  logic              sel_wr_en_i,
  input  logic [SEL_W-1:0]  sel_wr_data_i,
  input  logic              mode_wr_en_i,
  input  logic [SEL_W-1:0]  mode_wr_idx_i,
  input  logic [1:0]        mode_wr_data_i,
  input  logic              access_i,
  output logic [PTR_W-1:0]  addr_o
);
  logic [SEL_W-1:0] sel;
  logic [PTR_W-1:0] ptr_vals [NUM_PTRS];
  logic [NUM_PTRS-1:0] step_vec;

  ptr_select #(.NUM_PTRS(NUM_PTRS)) u_sel (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_wr_en_i  (sel_wr_en_i),
    .sel_wr_data_i(sel_wr_data_i),
    .sel_o        (sel)
  );

  for (genvar i = 0; i < NUM_PTRS; i++) begin : g_slot
    assign step_vec[i] = access_i && sel == SEL_W'(i);
    ptr_slot #(.PTR_W(PTR_W)) u_slot (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .step_en_i     (step_vec[i]),
      .wr_en_i       (ptr_wr_en_i && ptr_wr_idx_i == SEL_W'(i)),
      .wr_byte_i     (ptr_wr_byte_i),
      .wr_data_i     (ptr_wr_data_i),
      .mode_wr_en_i  (mode_wr_en_i && mode_wr_idx_i == SEL_W'(i)),
      .mode_wr_data_i(mode_wr_data_i),
      .ptr_o         (ptr_vals[i])
    );
  end

  assign addr_o = ptr_vals[sel];

  assert_single_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(step_vec) && (access_i || step_vec == '0));

  assert_addr_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access_i && !ptr_wr_en_i && !sel_wr_en_i |=> $stable(addr_o));
endmodule

// File: tb/addr_ptr_bank_tb.sv
`timescale 1ns/1ps
module addr_ptr_bank_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ptr_wr_en_i = 1'b0;
  logic        ptr_wr_idx_i = 1'b0;
  logic        ptr_wr_byte_i = 1'b0;
  logic [7:0]  ptr_wr_data_i = '0;
  logic        sel_wr_en_i = 1'b0;
  logic        sel_wr_data_i = 1'b0;
  logic        mode_wr_en_i = 1'b0;
  logic        mode_wr_idx_i = 1'b0;
  logic [1:0]  mode_wr_data_i = '0;
  logic        access_i = 1'b0;
  logic [15:0] addr_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] m_ptr [2];
  logic [1:0]  m_mode [2];
  logic        m_sel;

  always #2.5 clk_i = ~clk_i;

  addr_ptr_bank dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ptr_wr_en_i(ptr_wr_en_i), .ptr_wr_idx_i(ptr_wr_idx_i),
    .ptr_wr_byte_i(ptr_wr_byte_i), .ptr_wr_data_i(ptr_wr_data_i),
    .sel_wr_en_i(sel_wr_en_i), .sel_wr_data_i(sel_wr_data_i),
    .mode_wr_en_i(mode_wr_en_i), .mode_wr_idx_i(mode_wr_idx_i),
    .mode_wr_data_i(mode_wr_data_i), .access_i(access_i), .addr_o(addr_o)
  );

  function automatic logic [15:0] step_of(logic [1:0] md, logic [15:0] v);
    if (md == 2'b01) return v + 16'd1;
    if (md == 2'b10) return v - 16'd1;
    return v;
  endfunction

  task automatic check(string req, logic [15:0] exp);
    n_chk++;
    if (addr_o !== exp) begin
      n_fail++;
      $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  // one cycle: check pre-edge against model, apply edge to model, clear inputs
  task automatic tick(string req);
    #1 check(req, m_ptr[m_sel]);
    @(posedge clk_i);
    begin
      logic [15:0] np [2];
      np = m_ptr;
      if (access_i && !(ptr_wr_en_i && ptr_wr_idx_i == m_sel))
        np[m_sel] = step_of(m_mode[m_sel], m_ptr[m_sel]);
      if (ptr_wr_en_i) begin
        if (ptr_wr_byte_i) np[ptr_wr_idx_i][15:8] = ptr_wr_data_i;
        else               np[ptr_wr_idx_i][7:0]  = ptr_wr_data_i;
      end
      if (mode_wr_en_i) m_mode[mode_wr_idx_i] = mode_wr_data_i;
      if (sel_wr_en_i)  m_sel = sel_wr_data_i;
      m_ptr = np;
    end
    @(negedge clk_i);
    ptr_wr_en_i = 0; sel_wr_en_i = 0; mode_wr_en_i = 0; access_i = 0;
  endtask

  task automatic wr_byte(logic idx, logic hi, logic [7:0] d);
    ptr_wr_en_i = 1; ptr_wr_idx_i = idx; ptr_wr_byte_i = hi; ptr_wr_data_i = d;
    tick("R3");
  endtask

  task automatic wr_ptr(logic idx, logic [15:0] v);
    wr_byte(idx, 1'b0, v[7:0]);
    wr_byte(idx, 1'b1, v[15:8]);
  endtask

  task automatic wr_mode(logic idx, logic [1:0] md);
    mode_wr_en_i = 1; mode_wr_idx_i = idx; mode_wr_data_i = md;
    tick("R4");
  endtask

  task automatic wr_sel(logic s);
    sel_wr_en_i = 1; sel_wr_data_i = s;
    tick("R2");
  endtask

  task automatic strobe(string req);
    access_i = 1;
    tick(req);
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_ptr[0] = 0; m_ptr[1] = 0; m_mode[0] = 0; m_mode[1] = 0; m_sel = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1 check("R1 reset value", 16'h0000);
    @(negedge clk_i);
    strobe("R1");
    #1 check("R1 strobe after reset holds", 16'h0000);

    wr_byte(0, 0, 8'h34);
    #1 check("R3 low byte", 16'h0034);
    wr_byte(0, 1, 8'h12);
    #1 check("R3 high byte", 16'h1234);

    wr_sel(1);
    #1 check("R2 select p1", 16'h0000);
    wr_ptr(1, 16'hA000);
    #1 check("R3 p1 load", 16'hA000);
    wr_sel(0);
    #1 check("R2 select p0", 16'h1234);

    wr_mode(0, 2'b01);
    for (int k = 0; k < 3; k++) begin
      access_i = 1;
      #1 check("R5 pre-step value during strobe", 16'h1234 + 16'(k));
      tick("R5");
    end
    #1 check("R4 increment x3", 16'h1237);
    wr_sel(1);
    #1 check("R5 inactive pointer fixed", 16'hA000);
    strobe("R4");
    #1 check("R4 hold mode", 16'hA000);
    wr_sel(0);

    wr_ptr(0, 16'hFFFF);
    strobe("R6");
    #1 check("R6 increment wrap", 16'h0000);
    wr_mode(0, 2'b10);
    strobe("R6");
    #1 check("R6 decrement wrap", 16'hFFFF);
    strobe("R4");
    #1 check("R4 decrement", 16'hFFFE);

    wr_mode(0, 2'b11);
    strobe("R7");
    #1 check("R7 reserved holds", 16'hFFFE);

    wr_mode(0, 2'b01);
    wr_ptr(0, 16'h12FF);
    access_i = 1; ptr_wr_en_i = 1; ptr_wr_idx_i = 0; ptr_wr_byte_i = 1; ptr_wr_data_i = 8'h40;
    tick("R8");
    #1 check("R8 write beats step, low byte kept", 16'h40FF);

    access_i = 1; sel_wr_en_i = 1; sel_wr_data_i = 1;
    mode_wr_en_i = 1; mode_wr_idx_i = 0; mode_wr_data_i = 2'b10;
    tick("R9");
    #1 check("R9 old select used, p1 untouched", 16'hA000);
    wr_sel(0);
    #1 check("R9 old mode used for p0 step", 16'h4100);

    access_i = 1; ptr_wr_en_i = 1; ptr_wr_idx_i = 1; ptr_wr_byte_i = 0; ptr_wr_data_i = 8'h55;
    tick("R10");
    #1 check("R10 active stepped", 16'h40FF);
    wr_sel(1);
    #1 check("R10 inactive written", 16'hA055);

    for (int n = 0; n < 3000; n++) begin
      access_i       = ($urandom % 2) == 0;
      ptr_wr_en_i    = ($urandom % 5) == 0;
      ptr_wr_idx_i   = 1'($urandom);
      ptr_wr_byte_i  = 1'($urandom);
      ptr_wr_data_i  = 8'($urandom);
      sel_wr_en_i    = ($urandom % 8) == 0;
      sel_wr_data_i  = 1'($urandom);
      mode_wr_en_i   = ($urandom % 8) == 0;
      mode_wr_idx_i  = 1'($urandom);
      mode_wr_data_i = 2'($urandom);
      tick("R5 random model");
    end
    #1 check("R5 random final", m_ptr[m_sel]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule